// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit maps a logical reference, given as a segment selector plus an index, onto a physical address. Four segments are handled (absolute, program, data, stack). Each one has a base value and a size limit. The unit adds the chosen base to the index and compares the index against the chosen limit. An index past the limit, or a sum that does not fit in the physical width, produces a protection fault rather than an address.

The base and limit storage is held once per interrupt level. The current level picks which bank a translation reads, so a level change needs no save or restore of segment state. Writes name their target bank explicitly. Only supervisor-mode writes take effect. A user-mode write is dropped and reported on a separate flag.

Results are registered. A request made in one cycle returns its address, fault and level in the next cycle.

Top module: `seg_xlat_unit`

## Requirements
- R1: A valid request yields rsp_addr = base + index for the selected segment and level. Segment codes are: 0 absolute, 1 program, 2 data, 3 stack. rsp_addr_vld is 1 in that case.
- R2: When the index is greater than or equal to the selected limit, rsp_fault is 1, rsp_addr is 0 and rsp_addr_vld is 0.
- R3: When base + index does not fit in PA_W bits, rsp_fault is 1, rsp_addr is 0 and rsp_addr_vld is 0. A result that is accepted is never smaller than its index.
- R4: rsp_valid is req_valid delayed by exactly one cycle, and rsp_level carries the cur_level of that request.
- R5: A translation reads the bank selected by cur_level. A write changes only the entry named by wr_level and wr_seg, so the other banks and segments keep their contents.
- R6: Writes take effect only when supervisor is 1. A write with supervisor at 0 changes nothing, and priv_violation is 1 for exactly the following cycle. Otherwise priv_violation is 0.
- R7: After reset, rsp_valid and priv_violation are 0, and every base and limit is 0, so every access faults.
- R8: A request in the same cycle as a write to its entry uses the contents from before the write. The new value applies from the next request on.
- R9: wr_is_limit = 1 writes the limit, which takes the low IDX_W+1 bits of wr_data. wr_is_limit = 0 writes the base, which takes all PA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request this cycle |
| req_seg | input | 2 | Segment selector |
| req_index | input | IDX_W | Index within the segment |
| cur_level | input | LVL_W | Current interrupt level (bank for translation) |
| supervisor | input | 1 | 1 when the writer is in supervisor mode |
| wr_en | input | 1 | Register write strobe |
| wr_level | input | LVL_W | Bank targeted by the write |
| wr_seg | input | 2 | Segment targeted by the write |
| wr_is_limit | input | 1 | 1 writes the limit, 0 writes the base |
| wr_data | input | PA_W | Write value |
| rsp_valid | output | 1 | Result valid |
| rsp_addr_vld | output | 1 | Result carries a usable address |
| rsp_addr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 1 | Protection fault |
| rsp_level | output | LVL_W | Level the result was translated under |
| priv_violation | output | 1 | A user-mode write was refused last cycle |

## Verification
The assertions check the following on every cycle:
- the one-cycle request-to-result timing and the level echo;
- that a fault always blanks the address and clears rsp_addr_vld;
- that an accepted address never wraps below its index;
- the exact timing of the privilege flag.

Other behaviour depends on the stored contents, so only the bench scenarios can show it:
- the sums themselves;
- the limit boundary at index = limit - 1 and index = limit;
- isolation between banks;
- that refused writes leave state unchanged;
- that a same-cycle request sees the old contents.

The bench sweeps indices over every level and segment and computes each expected result arithmetically.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;
    typedef enum logic [1:0] {
        SEG_ABS   = 2'd0,
        SEG_PROG  = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_STACK = 2'd3
    } seg_sel_e;

    localparam int SEG_W = 2;
    localparam int SEG_N = 4;
endpackage

// File: rtl/seg_bank_regs.sv
module seg_bank_regs
    import seg_xlat_pkg::*;
#(
    parameter int LVL_W = 2,
    parameter int PA_W  = 16,
    parameter int LIM_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_level,
    input  seg_sel_e         wr_seg,
    input  logic             wr_is_limit,
    input  logic [PA_W-1:0]  wr_data,
    input  logic [LVL_W-1:0] rd_level,
    input  seg_sel_e         rd_seg,
    output logic [PA_W-1:0]  rd_base,
    output logic [LIM_W-1:0] rd_limit
);
    localparam int ENT_W = LVL_W + SEG_W;
    localparam int ENT_N = 1 << ENT_W;

    logic [PA_W-1:0]  base_arr [ENT_N];
    logic [LIM_W-1:0] lim_arr  [ENT_N];
    logic [ENT_W-1:0] wr_ent;
    logic [ENT_W-1:0] rd_ent;

    assign wr_ent = {wr_level, wr_seg};
    assign rd_ent = {rd_level, rd_seg};

    for (genvar e = 0; e < ENT_N; e++) begin : g_ent
        logic [PA_W-1:0]  base_d, base_q;
        logic [LIM_W-1:0] lim_d, lim_q;
        logic             hit;

        assign hit = wr_en && (wr_ent == ENT_W'(e));

        always_comb begin
            base_d = base_q;
            lim_d  = lim_q;
            if (hit) begin
                if (wr_is_limit) lim_d  = wr_data[LIM_W-1:0];
                else             base_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                lim_q  <= '0;
            end else begin
                base_q <= base_d;
                lim_q  <= lim_d;
            end
        end

        assign base_arr[e] = base_q;
        assign lim_arr[e]  = lim_q;
    end

    always_comb begin
        rd_base  = base_arr[rd_ent];
        rd_limit = lim_arr[rd_ent];
    end
endmodule

// File: rtl/seg_xlat_calc.sv
module seg_xlat_calc #(
    parameter int IDX_W = 12,
    parameter int PA_W  = 16,
    parameter int LIM_W = 13
) (
    input  logic [PA_W-1:0]  base,
    input  logic [LIM_W-1:0] limit,
    input  logic [IDX_W-1:0] index,
    output logic [PA_W-1:0]  phys,
    output logic             range_bad,
    output logic             wrap_bad
);
    logic [PA_W:0]    sum;
    logic [LIM_W-1:0] idx_ext;

    always_comb begin
        idx_ext   = LIM_W'(index);
        sum       = {1'b0, base} + (PA_W + 1)'(index);
        phys      = sum[PA_W-1:0];
        wrap_bad  = sum[PA_W];
        range_bad = (idx_ext >= limit);
    end
endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
    import seg_xlat_pkg::*;
#(
    parameter int IDX_W = 12,
    parameter int PA_W  = 16,
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_seg,
    input  logic [IDX_W-1:0] req_index,
    input  logic [LVL_W-1:0] cur_level,
    input  logic             supervisor,
    input  logic             wr_en,
    input  logic [LVL_W-1:0] wr_level,
    input  logic [1:0]       wr_seg,
    input  logic             wr_is_limit,
    input  logic [PA_W-1:0]  wr_data,
    output logic             rsp_valid,
    output logic             rsp_addr_vld,
    output logic [PA_W-1:0]  rsp_addr,
    output logic             rsp_fault,
    output logic [LVL_W-1:0] rsp_level,
    output logic             priv_violation
);
    localparam int LIM_W = IDX_W + 1;

    typedef struct packed {
        logic             valid;
        logic             addr_vld;
        logic             fault;
        logic [PA_W-1:0]  addr;
        logic [LVL_W-1:0] level;
        logic             priv;
    } rsp_t;

    rsp_t             st_d, st_q;
    logic             wr_ok;
    logic [PA_W-1:0]  sel_base;
    logic [LIM_W-1:0] sel_limit;
    logic [PA_W-1:0]  phys;
    logic             range_bad;
    logic             wrap_bad;

    assign wr_ok = wr_en && supervisor;

    seg_bank_regs #(
        .LVL_W (LVL_W),
        .PA_W  (PA_W),
        .LIM_W (LIM_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_ok),
        .wr_level    (wr_level),
        .wr_seg      (seg_sel_e'(wr_seg)),
        .wr_is_limit (wr_is_limit),
        .wr_data     (wr_data),
        .rd_level    (cur_level),
        .rd_seg      (seg_sel_e'(req_seg)),
        .rd_base     (sel_base),
        .rd_limit    (sel_limit)
    );

    seg_xlat_calc #(
        .IDX_W (IDX_W),
        .PA_W  (PA_W),
        .LIM_W (LIM_W)
    ) calc_i (
        .base      (sel_base),
        .limit     (sel_limit),
        .index     (req_index),
        .phys      (phys),
        .range_bad (range_bad),
        .wrap_bad  (wrap_bad)
    );

    always_comb begin
        st_d          = '0;
        st_d.valid    = req_valid;
        st_d.level    = cur_level;
        st_d.fault    = req_valid && (range_bad || wrap_bad);
        st_d.addr_vld = req_valid && !(range_bad || wrap_bad);
        st_d.addr     = st_d.addr_vld ? phys : '0;
        st_d.priv     = wr_en && !supervisor;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid      = st_q.valid;
    assign rsp_addr_vld   = st_q.addr_vld;
    assign rsp_addr       = st_q.addr;
    assign rsp_fault      = st_q.fault;
    assign rsp_level      = st_q.level;
    assign priv_violation = st_q.priv;
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
    parameter int IDX_W = 12,
    parameter int PA_W  = 16,
    parameter int LVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_index,
    input logic [LVL_W-1:0] cur_level,
    input logic             supervisor,
    input logic             wr_en,
    input logic             rsp_valid,
    input logic             rsp_addr_vld,
    input logic [PA_W-1:0]  rsp_addr,
    input logic             rsp_fault,
    input logic [LVL_W-1:0] rsp_level,
    input logic             priv_violation
);
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_level_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_level == $past(cur_level)));
    assert_fault_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && !rsp_addr_vld && rsp_addr == '0));
    assert_addr_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_addr_vld |-> (rsp_valid && !rsp_fault));
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_addr_vld |-> (rsp_addr >= PA_W'($past(req_index))));
    assert_priv_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !supervisor) |=> priv_violation);
    assert_priv_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !supervisor) |=> !priv_violation);
endmodule

bind seg_xlat_unit seg_xlat_chk #(
    .IDX_W (IDX_W),
    .PA_W  (PA_W),
    .LVL_W (LVL_W)
) chk_i (.*);

// File: tb/seg_xlat_unit_tb_top.sv
module seg_xlat_unit_tb_top;
    localparam int IDX_W = 12;
    localparam int PA_W  = 16;
    localparam int LVL_W = 2;
    localparam int LIM_MASK = (1 << (IDX_W + 1)) - 1;
    localparam int PA_MAX   = (1 << PA_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_seg = '0;
    logic [IDX_W-1:0] req_index = '0;
    logic [LVL_W-1:0] cur_level = '0;
    logic             supervisor = 1'b0;
    logic             wr_en = 1'b0;
    logic [LVL_W-1:0] wr_level = '0;
    logic [1:0]       wr_seg = '0;
    logic             wr_is_limit = 1'b0;
    logic [PA_W-1:0]  wr_data = '0;
    logic             rsp_valid, rsp_addr_vld, rsp_fault, priv_violation;
    logic [PA_W-1:0]  rsp_addr;
    logic [LVL_W-1:0] rsp_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    int m_base [4][4];
    int m_lim  [4][4];

    always #4 clk = ~clk;

    seg_xlat_unit #(.IDX_W(IDX_W), .PA_W(PA_W), .LVL_W(LVL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_index(req_index), .cur_level(cur_level), .supervisor(supervisor),
        .wr_en(wr_en), .wr_level(wr_level), .wr_seg(wr_seg),
        .wr_is_limit(wr_is_limit), .wr_data(wr_data), .rsp_valid(rsp_valid),
        .rsp_addr_vld(rsp_addr_vld), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .rsp_level(rsp_level), .priv_violation(priv_violation));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one write; after it, priv_violation reflects that write (R6).
    task automatic do_write(int lvl, int seg, bit lim, int data, bit sup);
        @(negedge clk);
        wr_en = 1; wr_level = LVL_W'(lvl); wr_seg = 2'(seg);
        wr_is_limit = lim; wr_data = PA_W'(data); supervisor = sup;
        @(negedge clk);
        wr_en = 0; supervisor = 0;
        chk("R6 priv_violation", int'(priv_violation), sup ? 0 : 1);
        if (sup) begin
            if (lim) m_lim[lvl][seg] = data & LIM_MASK;   // R9
            else     m_base[lvl][seg] = data & PA_MAX;
        end
    endtask

    task automatic expect_rsp(string tag, int lvl, int seg, int idx);
        bit f;
        int sum;
        sum = m_base[lvl][seg] + idx;
        f = (idx >= m_lim[lvl][seg]) || (sum > PA_MAX);
        chk({tag, " valid R4"}, int'(rsp_valid), 1);
        chk({tag, " level R4"}, int'(rsp_level), lvl);
        chk({tag, " fault R2/R3"}, int'(rsp_fault), int'(f));
        chk({tag, " addr_vld R2"}, int'(rsp_addr_vld), int'(!f));
        chk({tag, " addr R1"}, int'(rsp_addr), f ? 0 : sum);
    endtask

    task automatic xlate(string tag, int lvl, int seg, int idx);
        @(negedge clk);
        req_valid = 1; cur_level = LVL_W'(lvl); req_seg = 2'(seg);
        req_index = IDX_W'(idx);
        @(negedge clk);
        req_valid = 0;
        expect_rsp(tag, lvl, seg, idx);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 4; s++) begin
                m_base[l][s] = 0; m_lim[l][s] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R7: reset state
        chk("R7 rsp_valid after reset", int'(rsp_valid), 0);
        chk("R7 priv after reset", int'(priv_violation), 0);
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 4; s++) xlate("R7 cleared", l, s, l * 100 + s);

        // R5/R9: program all banks with distinct values
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 4; s++) begin
                do_write(l, s, 0, l * 4096 + s * 1024 + 3 * l + s, 1);
                do_write(l, s, 1, (l == 3 && s == 3) ? 4096 : (l * 4 + s) * 250 + 17, 1);
            end

        // R1/R2/R5: sweep indices across all banks and segments
        for (int l = 0; l < 4; l++)
            for (int s = 0; s < 4; s++) begin
                for (int i = 0; i < 4096; i += 13) xlate("sweep R1", l, s, i);
                for (int d = -1; d <= 1; d++) begin
                    int b = m_lim[l][s] + d;
                    if (b >= 0 && b < 4096) xlate("boundary R2", l, s, b);
                end
            end

        // R3: overflow of the physical width
        do_write(0, 3, 0, 16'hFF00, 1);
        do_write(0, 3, 1, 4096, 1);
        xlate("top fits R3", 0, 3, 16'h00FF);
        xlate("wrap R3", 0, 3, 16'h0100);
        xlate("wrap far R3", 0, 3, 4095);

        // R6: user write ignored, flagged
        do_write(1, 2, 0, 16'h0123, 0);
        do_write(1, 2, 1, 0, 0);
        xlate("after user write R6", 1, 2, 5);
        xlate("after user write R6 b", 1, 2, m_lim[1][2] - 1);
        @(negedge clk);
        chk("R6 flag one cycle", int'(priv_violation), 0);
        chk("R4 idle rsp_valid", int'(rsp_valid), 0);

        // R8: same-cycle write and request sees old contents
        @(negedge clk);
        req_valid = 1; cur_level = 2; req_seg = 1; req_index = 12'd40;
        wr_en = 1; supervisor = 1; wr_level = 2; wr_seg = 1;
        wr_is_limit = 0; wr_data = 16'h3000;
        @(negedge clk);
        req_valid = 0; wr_en = 0; supervisor = 0;
        expect_rsp("same-cycle R8", 2, 1, 40);
        m_base[2][1] = 16'h3000;
        xlate("after write R8", 2, 1, 40);
        chk("R8 new base used", int'(rsp_addr), 16'h3000 + 40);

        // R8/R2: limit shrunk to zero in same cycle as a request
        @(negedge clk);
        req_valid = 1; cur_level = 3; req_seg = 0; req_index = 12'd1;
        wr_en = 1; supervisor = 1; wr_level = 3; wr_seg = 0;
        wr_is_limit = 1; wr_data = 16'h0000;
        @(negedge clk);
        req_valid = 0; wr_en = 0; supervisor = 0;
        expect_rsp("same-cycle limit R8", 3, 0, 1);
        m_lim[3][0] = 0;
        xlate("zero limit R2", 3, 0, 0);

        // R9: limit takes low IDX_W+1 bits only
        do_write(1, 0, 1, 16'hE00A, 1);
        xlate("limit mask R9 in", 1, 0, 9);
        xlate("limit mask R9 out", 1, 0, 10);

        // R5: other banks untouched by the writes above
        xlate("isolation R5", 0, 1, 100);
        xlate("isolation R5 b", 3, 3, 4095);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule